// File: doc/BRIEF.md
# Dual-Bus Cross Access Arbiter

This block sits between two processor buses in a two-processor system. A 16-bit main processor owns a main bus carrying ROM, work RAM, a video port and I/O, while an 8-bit sound coprocessor owns a smaller local bus. Each processor reaches its own bus directly. To reach the other side, it must first raise a bus request and wait for the matching grant. Only then is its access carried across.

The main processor sees the whole coprocessor address space through one 64 KB page of its own address map. The coprocessor reaches the main space through a 32 KB window. The upper address bits for that window come from a bank register, which the coprocessor loads one bit per write.

A third master, a DMA engine that copies ROM or work RAM data into the video port, can take over the main bus. It wins over both processors at every arbitration point. Each master presents a valid/ready access. An access that cannot proceed is held with its wait output high until the path opens.

Top module: `xbus_arbiter`

## Requirements
- R1: While reset is active, and in the cycles after it, no grant is asserted and neither bus carries a valid access while no master presents one.
- R2: A main-processor access outside the coprocessor page goes to the main bus unchanged while the main processor owns that bus. Its read data and ready come straight back from the main bus.
- R3: A main-processor access whose address bits [23:16] equal the coprocessor page (0xA0) stalls with mc_wait high and mc_ready low until mc_busgnt is high. It then appears on the coprocessor bus with address bits [15:0] and write data bits [7:0].
- R4: A grant rises one clock after a cycle in which the requested bus has no unfinished access (valid high with ready low). For the coprocessor bus, the coprocessor must also present no local access in that cycle.
- R5: A grant stays high for as long as its request stays high, and falls one clock after the request drops.
- R6: A coprocessor write to address 0x6000 completes in the same cycle without touching either bus. It shifts data bit 0 into the MSB of the 9-bit bank register, so the first of nine writes ends up in bit 0.
- R7: A coprocessor access with address bit 15 set is placed on the main bus at address {bank, cc_addr[14:0]}, on byte lane [7:0], only while cc_busgnt is high; otherwise it stalls with cc_wait high.
- R8: On the main bus, a DMA request wins over a pending coprocessor request. A main-processor access presented in the deciding cycle keeps the coprocessor from being granted.
- R9: While dma_gnt is high, the DMA master drives the main bus and a main-processor access to the main bus waits with mc_wait high.
- R10: dma_gnt and cc_busgnt are never high together.
- R11: While the main processor holds the coprocessor bus, a local coprocessor access stalls with cc_wait high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_valid | input | 1 | Main processor access valid |
| mc_we | input | 1 | Main processor write |
| mc_addr | input | 24 | Main processor address |
| mc_wdata | input | 16 | Main processor write data |
| mc_rdata | output | 16 | Main processor read data |
| mc_ready | output | 1 | Main processor access completes |
| mc_wait | output | 1 | Main processor stalled for lack of a grant |
| mc_busreq | input | 1 | Main processor requests the coprocessor bus |
| mc_busgnt | output | 1 | Coprocessor bus granted to main processor |
| cc_valid | input | 1 | Coprocessor access valid |
| cc_we | input | 1 | Coprocessor write |
| cc_addr | input | 16 | Coprocessor address |
| cc_wdata | input | 8 | Coprocessor write data |
| cc_rdata | output | 8 | Coprocessor read data |
| cc_ready | output | 1 | Coprocessor access completes |
| cc_wait | output | 1 | Coprocessor stalled for lack of a grant |
| cc_busreq | input | 1 | Coprocessor requests the main bus |
| cc_busgnt | output | 1 | Main bus granted to coprocessor |
| dma_req | input | 1 | DMA requests the main bus |
| dma_gnt | output | 1 | Main bus granted to DMA |
| dma_valid | input | 1 | DMA access valid |
| dma_we | input | 1 | DMA write |
| dma_addr | input | 24 | DMA address |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA read data |
| dma_ready | output | 1 | DMA access completes |
| mb_valid | output | 1 | Main bus access valid |
| mb_we | output | 1 | Main bus write |
| mb_addr | output | 24 | Main bus address |
| mb_wdata | output | 16 | Main bus write data |
| mb_rdata | input | 16 | Main bus read data |
| mb_ready | input | 1 | Main bus slave ready |
| cb_valid | output | 1 | Coprocessor bus access valid |
| cb_we | output | 1 | Coprocessor bus write |
| cb_addr | output | 16 | Coprocessor bus address |
| cb_wdata | output | 8 | Coprocessor bus write data |
| cb_rdata | input | 8 | Coprocessor bus read data |
| cb_ready | input | 1 | Coprocessor bus slave ready |

## Verification
The bench builds the block with its default parameters: a 24-bit main address, 16-bit main data, 16-bit coprocessor address, 8-bit coprocessor data, coprocessor page 0xA0 and bank register address 0x6000. These defaults give a 9-bit bank. A full nine-write bank load therefore fits in a few cycles, and the bench can predict the exact window address for a chosen bank value. With slave ready under bench control, the bench can hold a bus cycle open and show that a grant waits for it to finish.

// File: rtl/xba_pkg.sv
package xba_pkg;
  typedef enum logic [1:0] {
    MOWN_CPU = 2'd0,
    MOWN_DMA = 2'd1,
    MOWN_COP = 2'd2
  } mown_e;
endpackage

// File: rtl/xba_mbus_arb.sv
module xba_mbus_arb
  import xba_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dma_req,
  input  logic  cop_req,
  input  logic  cpu_main,
  input  logic  bus_busy,
  output mown_e owner
);
  mown_e own_q, own_d;
  logic  own_en;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      MOWN_CPU: begin
        if (!bus_busy) begin
          if (dma_req)                   own_d = MOWN_DMA;
          else if (cop_req && !cpu_main) own_d = MOWN_COP;
        end
      end
      MOWN_DMA: if (!dma_req) own_d = MOWN_CPU;
      MOWN_COP: if (!cop_req) own_d = MOWN_CPU;
      default:  own_d = MOWN_CPU;
    endcase
  end

  assign own_en = (own_d != own_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= MOWN_CPU;
    else if (own_en) own_q <= own_d;
  end

  assign owner = own_q;

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({own_q == MOWN_DMA, own_q == MOWN_COP}));
  a_r5_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == MOWN_DMA && dma_req) |=> (own_q == MOWN_DMA));
  a_r5_cop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == MOWN_COP && cop_req) |=> (own_q == MOWN_COP));
  a_r4_dma_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == MOWN_CPU && bus_busy) |=> (own_q == MOWN_CPU));
  a_r8_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == MOWN_CPU && dma_req) |=> (own_q != MOWN_COP));
endmodule

// File: rtl/xba_cbus_arb.sv
module xba_cbus_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic cop_local,
  input  logic bus_busy,
  output logic gnt
);
  logic gnt_q, gnt_d, gnt_en;

  always_comb begin
    if (!gnt_q) gnt_d = req && !bus_busy && !cop_local;
    else        gnt_d = req;
  end

  assign gnt_en = (gnt_d != gnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= 1'b0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;

  a_r4_cbus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_q && (bus_busy || cop_local)) |=> !gnt_q);
  a_r5_cbus_release: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !gnt_q);
endmodule

// File: rtl/xba_bank_reg.sv
module xba_bank_reg #(
  parameter int unsigned BW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          din,
  output logic [BW-1:0] bank
);
  logic [BW-1:0] bank_q, bank_d;

  always_comb begin
    bank_d = {din, bank_q[BW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= bank_d;
  end

  assign bank = bank_q;

  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q[BW-1] == $past(din)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/xba_router.sv
module xba_router
  import xba_pkg::*;
#(
  parameter int unsigned MAW       = 24,
  parameter int unsigned MDW       = 16,
  parameter int unsigned CAW       = 16,
  parameter int unsigned CDW       = 8,
  parameter int unsigned COP_PAGE  = 'hA0,
  parameter int unsigned BANK_ADDR = 'h6000,
  localparam int unsigned WAW      = CAW - 1,
  localparam int unsigned BW       = MAW - WAW,
  localparam int unsigned PW       = MAW - CAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  mown_e          owner,
  input  logic           cgnt,
  input  logic [BW-1:0]  bank,
  input  logic           mc_valid,
  input  logic           mc_we,
  input  logic [MAW-1:0] mc_addr,
  input  logic [MDW-1:0] mc_wdata,
  output logic [MDW-1:0] mc_rdata,
  output logic           mc_ready,
  output logic           mc_wait,
  input  logic           cc_valid,
  input  logic           cc_we,
  input  logic [CAW-1:0] cc_addr,
  input  logic [CDW-1:0] cc_wdata,
  output logic [CDW-1:0] cc_rdata,
  output logic           cc_ready,
  output logic           cc_wait,
  input  logic           dma_valid,
  input  logic           dma_we,
  input  logic [MAW-1:0] dma_addr,
  input  logic [MDW-1:0] dma_wdata,
  output logic [MDW-1:0] dma_rdata,
  output logic           dma_ready,
  output logic           mb_valid,
  output logic           mb_we,
  output logic [MAW-1:0] mb_addr,
  output logic [MDW-1:0] mb_wdata,
  input  logic [MDW-1:0] mb_rdata,
  input  logic           mb_ready,
  output logic           cb_valid,
  output logic           cb_we,
  output logic [CAW-1:0] cb_addr,
  output logic [CDW-1:0] cb_wdata,
  input  logic [CDW-1:0] cb_rdata,
  input  logic           cb_ready,
  output logic           mb_busy,
  output logic           cb_busy,
  output logic           cpu_main,
  output logic           cop_local,
  output logic           bank_wr
);
  logic mc_cop, cc_bank, cc_win, cc_loc;

  assign mc_cop    = (mc_addr[MAW-1:CAW] == PW'(COP_PAGE));
  assign cc_bank   = cc_we && (cc_addr == CAW'(BANK_ADDR));
  assign cc_win    = cc_addr[CAW-1] && !cc_bank;
  assign cc_loc    = !cc_win && !cc_bank;
  assign cpu_main  = mc_valid && !mc_cop;
  assign cop_local = cc_valid && cc_loc;
  assign bank_wr   = cc_valid && cc_bank;

  // main bus source select
  always_comb begin
    mb_valid = 1'b0;
    mb_we    = 1'b0;
    mb_addr  = '0;
    mb_wdata = '0;
    unique case (owner)
      MOWN_CPU: if (cpu_main) begin
        mb_valid = 1'b1;
        mb_we    = mc_we;
        mb_addr  = mc_addr;
        mb_wdata = mc_wdata;
      end
      MOWN_DMA: if (dma_valid) begin
        mb_valid = 1'b1;
        mb_we    = dma_we;
        mb_addr  = dma_addr;
        mb_wdata = dma_wdata;
      end
      MOWN_COP: if (cc_valid && cc_win) begin
        mb_valid = 1'b1;
        mb_we    = cc_we;
        mb_addr  = {bank, cc_addr[WAW-1:0]};
        mb_wdata = {{(MDW-CDW){1'b0}}, cc_wdata};
      end
      default: ;
    endcase
  end

  // coprocessor bus source select
  always_comb begin
    cb_valid = 1'b0;
    cb_we    = 1'b0;
    cb_addr  = '0;
    cb_wdata = '0;
    if (cgnt) begin
      if (mc_valid && mc_cop) begin
        cb_valid = 1'b1;
        cb_we    = mc_we;
        cb_addr  = mc_addr[CAW-1:0];
        cb_wdata = mc_wdata[CDW-1:0];
      end
    end else if (cop_local) begin
      cb_valid = 1'b1;
      cb_we    = cc_we;
      cb_addr  = cc_addr;
      cb_wdata = cc_wdata;
    end
  end

  // responses to masters
  always_comb begin
    if (mc_cop) begin
      mc_rdata = {{(MDW-CDW){1'b0}}, cb_rdata};
      mc_ready = mc_valid && cgnt && cb_ready;
      mc_wait  = mc_valid && !cgnt;
    end else begin
      mc_rdata = mb_rdata;
      mc_ready = mc_valid && (owner == MOWN_CPU) && mb_ready;
      mc_wait  = mc_valid && (owner != MOWN_CPU);
    end
    if (cc_bank) begin
      cc_rdata = '0;
      cc_ready = cc_valid;
      cc_wait  = 1'b0;
    end else if (cc_win) begin
      cc_rdata = mb_rdata[CDW-1:0];
      cc_ready = cc_valid && (owner == MOWN_COP) && mb_ready;
      cc_wait  = cc_valid && (owner != MOWN_COP);
    end else begin
      cc_rdata = cb_rdata;
      cc_ready = cc_valid && !cgnt && cb_ready;
      cc_wait  = cc_valid && cgnt;
    end
    dma_rdata = mb_rdata;
    dma_ready = dma_valid && (owner == MOWN_DMA) && mb_ready;
  end

  assign mb_busy = mb_valid && !mb_ready;
  assign cb_busy = cb_valid && !cb_ready;

  a_r3_page_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && mc_cop && !cgnt) |-> (mc_wait && !mc_ready && !(cb_valid && cb_addr == mc_addr[CAW-1:0] && !cop_local)));
  a_r9_dma_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == MOWN_DMA && cpu_main) |-> (mc_wait && !mc_ready));
  a_r11_local_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cgnt && cop_local) |-> (cc_wait && !cc_ready));
  a_r6_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> (cc_ready && !(owner == MOWN_COP && mb_valid && mb_addr[WAW-1:0] == cc_addr[WAW-1:0])));
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xba_pkg::*;
#(
  parameter int unsigned MAW       = 24,
  parameter int unsigned MDW       = 16,
  parameter int unsigned CAW       = 16,
  parameter int unsigned CDW       = 8,
  parameter int unsigned COP_PAGE  = 'hA0,
  parameter int unsigned BANK_ADDR = 'h6000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mc_valid,
  input  logic           mc_we,
  input  logic [MAW-1:0] mc_addr,
  input  logic [MDW-1:0] mc_wdata,
  output logic [MDW-1:0] mc_rdata,
  output logic           mc_ready,
  output logic           mc_wait,
  input  logic           mc_busreq,
  output logic           mc_busgnt,
  input  logic           cc_valid,
  input  logic           cc_we,
  input  logic [CAW-1:0] cc_addr,
  input  logic [CDW-1:0] cc_wdata,
  output logic [CDW-1:0] cc_rdata,
  output logic           cc_ready,
  output logic           cc_wait,
  input  logic           cc_busreq,
  output logic           cc_busgnt,
  input  logic           dma_req,
  output logic           dma_gnt,
  input  logic           dma_valid,
  input  logic           dma_we,
  input  logic [MAW-1:0] dma_addr,
  input  logic [MDW-1:0] dma_wdata,
  output logic [MDW-1:0] dma_rdata,
  output logic           dma_ready,
  output logic           mb_valid,
  output logic           mb_we,
  output logic [MAW-1:0] mb_addr,
  output logic [MDW-1:0] mb_wdata,
  input  logic [MDW-1:0] mb_rdata,
  input  logic           mb_ready,
  output logic           cb_valid,
  output logic           cb_we,
  output logic [CAW-1:0] cb_addr,
  output logic [CDW-1:0] cb_wdata,
  input  logic [CDW-1:0] cb_rdata,
  input  logic           cb_ready
);
  localparam int unsigned BW = MAW - (CAW - 1);

  logic          rs_q1, rs_q2, srst_n;
  mown_e         owner;
  logic          cgnt;
  logic [BW-1:0] bank;
  logic          mb_busy, cb_busy, cpu_main, cop_local, bank_wr;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  xba_mbus_arb u_mbus_arb (
    .clk(clk), .rst_n(srst_n), .dma_req(dma_req), .cop_req(cc_busreq),
    .cpu_main(cpu_main), .bus_busy(mb_busy), .owner(owner)
  );

  xba_cbus_arb u_cbus_arb (
    .clk(clk), .rst_n(srst_n), .req(mc_busreq), .cop_local(cop_local),
    .bus_busy(cb_busy), .gnt(cgnt)
  );

  xba_bank_reg #(.BW(BW)) u_bank (
    .clk(clk), .rst_n(srst_n), .wr_en(bank_wr), .din(cc_wdata[0]), .bank(bank)
  );

  xba_router #(
    .MAW(MAW), .MDW(MDW), .CAW(CAW), .CDW(CDW),
    .COP_PAGE(COP_PAGE), .BANK_ADDR(BANK_ADDR)
  ) u_router (
    .clk(clk), .rst_n(srst_n), .owner(owner), .cgnt(cgnt), .bank(bank),
    .mc_valid(mc_valid), .mc_we(mc_we), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
    .mc_rdata(mc_rdata), .mc_ready(mc_ready), .mc_wait(mc_wait),
    .cc_valid(cc_valid), .cc_we(cc_we), .cc_addr(cc_addr), .cc_wdata(cc_wdata),
    .cc_rdata(cc_rdata), .cc_ready(cc_ready), .cc_wait(cc_wait),
    .dma_valid(dma_valid), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_ready(dma_ready),
    .mb_valid(mb_valid), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .mb_ready(mb_ready),
    .cb_valid(cb_valid), .cb_we(cb_we), .cb_addr(cb_addr), .cb_wdata(cb_wdata),
    .cb_rdata(cb_rdata), .cb_ready(cb_ready),
    .mb_busy(mb_busy), .cb_busy(cb_busy), .cpu_main(cpu_main),
    .cop_local(cop_local), .bank_wr(bank_wr)
  );

  assign mc_busgnt = cgnt;
  assign cc_busgnt = (owner == MOWN_COP);
  assign dma_gnt   = (owner == MOWN_DMA);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !srst_n |-> (!mc_busgnt && !cc_busgnt && !dma_gnt));
  a_r10_grants: assert property (@(posedge clk) disable iff (!srst_n)
    !(dma_gnt && cc_busgnt));
endmodule

// File: tb/xbus_arbiter_bench.sv
module xbus_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mc_valid, mc_we, mc_busreq;
  logic [23:0] mc_addr;
  logic [15:0] mc_wdata, mc_rdata;
  logic        mc_ready, mc_wait, mc_busgnt;
  logic        cc_valid, cc_we, cc_busreq;
  logic [15:0] cc_addr;
  logic [7:0]  cc_wdata, cc_rdata;
  logic        cc_ready, cc_wait, cc_busgnt;
  logic        dma_req, dma_gnt, dma_valid, dma_we, dma_ready;
  logic [23:0] dma_addr;
  logic [15:0] dma_wdata, dma_rdata;
  logic        mb_valid, mb_we, mb_ready;
  logic [23:0] mb_addr;
  logic [15:0] mb_wdata, mb_rdata;
  logic        cb_valid, cb_we, cb_ready;
  logic [15:0] cb_addr;
  logic [7:0]  cb_wdata, cb_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [8:0] bank_val = 9'h1A5;

  always #10 clk = ~clk;

  assign mb_rdata = mb_addr[15:0] ^ 16'h5A5A;
  assign cb_rdata = cb_addr[7:0] ^ 8'h3C;

  xbus_arbiter u_xbus_arbiter (
    .clk(clk), .rst_n(rst_n),
    .mc_valid(mc_valid), .mc_we(mc_we), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
    .mc_rdata(mc_rdata), .mc_ready(mc_ready), .mc_wait(mc_wait),
    .mc_busreq(mc_busreq), .mc_busgnt(mc_busgnt),
    .cc_valid(cc_valid), .cc_we(cc_we), .cc_addr(cc_addr), .cc_wdata(cc_wdata),
    .cc_rdata(cc_rdata), .cc_ready(cc_ready), .cc_wait(cc_wait),
    .cc_busreq(cc_busreq), .cc_busgnt(cc_busgnt),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .dma_valid(dma_valid), .dma_we(dma_we),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ready(dma_ready),
    .mb_valid(mb_valid), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .mb_ready(mb_ready),
    .cb_valid(cb_valid), .cb_we(cb_we), .cb_addr(cb_addr), .cb_wdata(cb_wdata),
    .cb_rdata(cb_rdata), .cb_ready(cb_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    mc_valid = 0; mc_we = 0; mc_addr = '0; mc_wdata = '0; mc_busreq = 0;
    cc_valid = 0; cc_we = 0; cc_addr = '0; cc_wdata = '0; cc_busreq = 0;
    dma_req = 0; dma_valid = 0; dma_we = 0; dma_addr = '0; dma_wdata = '0;
    mb_ready = 1; cb_ready = 1;
  endtask

  task automatic t_reset();
    idle_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 dma_gnt in reset", dma_gnt, 0);
    check("R1 cc_busgnt in reset", cc_busgnt, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 grants after reset", {mc_busgnt, cc_busgnt, dma_gnt}, 0);
    check("R1 buses quiet", {mb_valid, cb_valid}, 0);
  endtask

  task automatic t_main_local();
    @(negedge clk);
    mc_valid = 1; mc_addr = 24'h001234; mc_we = 0;
    #1;
    check("R2 mb_valid", mb_valid, 1);
    check("R2 mb_addr", mb_addr, 24'h001234);
    check("R2 mc_rdata", mc_rdata, 16'h1234 ^ 16'h5A5A);
    check("R2 ready/wait", {mc_ready, mc_wait}, 2'b10);
    mc_valid = 0;
  endtask

  task automatic t_main_cross();
    @(negedge clk);
    mc_valid = 1; mc_addr = 24'hA01000; mc_we = 1; mc_wdata = 16'h00AB;
    cc_valid = 1; cc_addr = 16'h0200; cc_we = 0; cb_ready = 0;
    mc_busreq = 1;
    #1;
    check("R3 stall without grant", {mc_wait, mc_ready}, 2'b10);
    check("R3 cop bus keeps local addr", cb_addr, 16'h0200);
    @(negedge clk);
    check("R4 no grant while cycle open", mc_busgnt, 0);
    cb_ready = 1;
    @(negedge clk);
    check("R4 no grant while coproc local", mc_busgnt, 0);
    cc_valid = 0;
    @(negedge clk);
    check("R4 grant after idle", mc_busgnt, 1);
    #1;
    check("R3 cross addr", cb_addr, 16'h1000);
    check("R3 cross wdata/we", {cb_we, cb_wdata}, {1'b1, 8'hAB});
    check("R3 ready", mc_ready, 1);
    cc_valid = 1;
    #1;
    check("R11 local waits", {cc_wait, cc_ready}, 2'b10);
    mc_valid = 0;
    @(negedge clk);
    check("R5 grant held", mc_busgnt, 1);
    mc_busreq = 0;
    @(negedge clk);
    check("R5 grant released", mc_busgnt, 0);
    #1;
    check("R11 local resumes", {cc_wait, cc_ready}, 2'b01);
    cc_valid = 0;
  endtask

  task automatic t_bank_window();
    logic [23:0] exp_addr;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cc_valid = 1; cc_we = 1; cc_addr = 16'h6000; cc_wdata = {7'd0, bank_val[i]};
      #1;
      if (i == 0) begin
        check("R6 bank write ready", {cc_ready, cc_wait}, 2'b10);
        check("R6 no bus touched", {mb_valid, cb_valid}, 0);
      end
    end
    @(negedge clk);
    cc_we = 0; cc_wdata = 0; cc_addr = 16'h8123;
    #1;
    check("R7 window stalls", {cc_wait, mb_valid}, 2'b10);
    cc_busreq = 1; mc_valid = 1; mc_addr = 24'h000100; mc_we = 0;
    @(negedge clk);
    check("R8 owner access blocks cop grant", cc_busgnt, 0);
    mc_valid = 0;
    @(negedge clk);
    check("R4 cop grant", cc_busgnt, 1);
    #1;
    exp_addr = {bank_val, 15'h0123};
    check("R7 window addr", mb_addr, exp_addr);
    check("R7 window rdata", cc_rdata, exp_addr[7:0] ^ 8'h5A);
    check("R7 window ready", cc_ready, 1);
    mc_valid = 1;
    #1;
    check("R7 main cpu waits", mc_wait, 1);
    mc_valid = 0; cc_valid = 0; cc_busreq = 0;
    @(negedge clk);
    check("R5 cop grant dropped", cc_busgnt, 0);
  endtask

  task automatic t_dma_priority();
    @(negedge clk);
    dma_req = 1; cc_busreq = 1;
    @(negedge clk);
    check("R8 dma wins", {dma_gnt, cc_busgnt}, 2'b10);
    check("R10 grants exclusive", dma_gnt & cc_busgnt, 0);
    dma_valid = 1; dma_we = 1; dma_addr = 24'hC00000; dma_wdata = 16'hBEEF;
    mc_valid = 1; mc_addr = 24'h000200;
    #1;
    check("R9 dma drives bus", {mb_addr, mb_wdata}, {24'hC00000, 16'hBEEF});
    check("R9 cpu waits", {mc_wait, mc_ready}, 2'b10);
    @(negedge clk);
    dma_req = 0; dma_valid = 0; mc_valid = 0;
    @(negedge clk);
    check("R5 dma released", {dma_gnt, cc_busgnt}, 2'b00);
    @(negedge clk);
    check("R8 cop after dma", cc_busgnt, 1);
    check("R10 exclusive", dma_gnt & cc_busgnt, 0);
    cc_busreq = 0;
    @(negedge clk);
  endtask

  task automatic t_dma_waits();
    @(negedge clk);
    mc_valid = 1; mc_addr = 24'h000300; mb_ready = 0; dma_req = 1;
    @(negedge clk);
    check("R4 dma waits for open cycle", dma_gnt, 0);
    mb_ready = 1;
    @(negedge clk);
    check("R4 dma granted after cycle", dma_gnt, 1);
    #1;
    check("R9 cpu stalled", {mc_wait, mb_valid}, 2'b10);
    idle_all();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_main_local();
    t_main_cross();
    t_bank_window();
    t_dma_priority();
    t_dma_waits();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule